// File: doc/BRIEF.md
# Power-Switch Override Mode Controller

This block keeps the operating state of a motion-sensing lamp controller. It looks at the stream of mains zero-cross pulses. When the wall switch is flicked off and back on, the pulse stream stops for a short time and then starts again. The block counts each of these flicks as a gesture. When enough gestures arrive close together, they form an override. An override does one of two things:

- shortly after power-up, it puts the controller into a short-hold test state;
- later on, it switches between automatic sensing and a forced-on state. The forced-on state gives itself up after a number of hours.

The block also times the power-on warm-up. A long loss of zero-cross restarts that warm-up from zero.

A separate selector input can pin the lamp on or off. While the selector does so, the block ignores gestures. The block drives three things towards the output stage: a trigger-enable flag, and two one-cycle flash requests. The slow request marks leaving automatic operation. The fast request marks returning to it.

All time intervals are counted in `tick` strobes. One tick is one time unit of the system time base. Parameters give each interval in ticks, so a fast simulation can shrink seconds and hours to a few cycles.

State codes on `state_o` are as follows:

| Code | State | Meaning |
|---|---|---|
| 0 | WARM | warm-up |
| 1 | TEST | test |
| 2 | AUTO | automatic sensing |
| 3 | OVR_ON | override on |
| 4 | FORCE_ON | forced on by the selector |
| 5 | FORCE_OFF | forced off by the selector |

Named transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| warm_done | WARM | AUTO | the initial time has run out |
| test_entry | WARM | TEST | override inside the early window |
| test_exit | TEST | AUTO or WARM | idle timeout |
| ovr_set | AUTO | OVR_ON | override |
| ovr_clear | OVR_ON | AUTO | override |
| ovr_expire | OVR_ON | AUTO | revert timeout |
| zc_restart | any non-forced state | WARM | zero-cross loss |
| force_on | any state | FORCE_ON | selector reads 01 |
| force_off | any state | FORCE_OFF | selector reads 10 |
| force_release | FORCE_ON or FORCE_OFF | AUTO or WARM | selector returns to automatic |

Top module: `ovr_mode_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (WARM), `trig_en` is 0 and both flash requests are 0. `state_o` only takes the codes 0 to 5.
- R2: A gesture is a resumed zero-cross pulse after a silence of more than GAP_TICKS and at most LOSS_TICKS ticks. An override is GESTURES gestures in a row, each within WINDOW_TICKS ticks of the one before. With a single gesture, every gesture is an override.
- R3: In WARM, an override that arrives before TEST_ENTRY_TICKS ticks of initial time have passed moves the state to TEST (test_entry). The move takes effect two clocks after the resuming pulse.
- R4: In TEST, a run of more than TEST_IDLE_TICKS ticks with no `trig_valid` ends the state (test_exit). The state goes to AUTO if the initial time has run out, otherwise to WARM.
- R5: WARM moves to AUTO once INIT_TICKS ticks of initial time have run (warm_done). `trig_en` is 1 only in TEST and AUTO.
- R6: An override in AUTO moves the state to OVR_ON (ovr_set). An override in OVR_ON moves it back to AUTO (ovr_clear).
- R7: OVR_ON falls back to AUTO on its own after REVERT_HOURS×HOUR_TICKS ticks (ovr_expire).
- R8: A zero-cross silence longer than LOSS_TICKS ticks drives any non-forced state to WARM. It also restarts the initial time from zero, with the same INIT_TICKS length (zc_restart).
- R9: Selector code 01 forces FORCE_ON and code 10 forces FORCE_OFF, one clock later. Gestures have no effect while forced. Codes 00 and 11 release the state to AUTO, or to WARM if the initial time has not run out.
- R10: When FLASH_EN is set, `flash_slow` pulses for one cycle when the state enters TEST or OVR_ON. `flash_fast` pulses for one cycle when TEST or OVR_ON hands back to AUTO or WARM. Changes made by the selector raise neither request.
- R11: A partial gesture count that sees no further gesture within WINDOW_TICKS ticks is dropped, and the state is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base strobe; every interval is counted in ticks |
| zc_pulse | input | 1 | One-cycle zero-cross pulse from the mains detector |
| mode_sel | input | 2 | Selector: 01 forced on, 10 forced off, 00/11 automatic |
| trig_valid | input | 1 | Strobe for a qualified motion trigger |
| state_o | output | 3 | Current state code (0 to 5) |
| trig_en | output | 1 | Motion triggers are accepted |
| flash_slow | output | 1 | Request for the slow flash pattern (leaving automatic) |
| flash_fast | output | 1 | Request for the fast flash pattern (returning to automatic) |

## Verification
The bench drives the following corner cases:

- Two flicks that fall inside the gesture window. A design with a bad window would never enter TEST or OVR_ON.
- A lone flick left to expire. A design that kept a stale count would fire a spurious override later.
- Idle expiry in TEST before the initial time is over. A design that jumped straight to AUTO here would enable sensing during warm-up.
- Gestures while the selector forces the state. A design that leaked them would raise flash requests or change state.
- A mains silence just past the loss limit. A design that treated it as a gesture, or kept the old initial count, would turn sensing on early after the restart.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

    typedef enum logic [2:0] {
        ST_WARM      = 3'd0,
        ST_TEST      = 3'd1,
        ST_AUTO      = 3'd2,
        ST_OVR_ON    = 3'd3,
        ST_FORCE_ON  = 3'd4,
        ST_FORCE_OFF = 3'd5
    } ovr_state_e;

    localparam logic [1:0] SEL_ON  = 2'b01;
    localparam logic [1:0] SEL_OFF = 2'b10;

endpackage

// File: rtl/ovr_zc_gesture.sv
module ovr_zc_gesture #(
    parameter int GAP_TICKS    = 40,
    parameter int LOSS_TICKS   = 3000,
    parameter int WINDOW_TICKS = 3000,
    parameter int GESTURES     = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic zc_pulse,
    output logic ovr_q,
    output logic loss_q
);

    localparam int GW = $clog2(LOSS_TICKS + 2);
    localparam logic [GW-1:0] GAP_L  = GW'(GAP_TICKS);
    localparam logic [GW-1:0] LOSS_L = GW'(LOSS_TICKS);
    localparam logic [GW-1:0] G_ONE  = GW'(1);

    logic [GW-1:0] silence;
    logic          gest_ev;
    logic          loss_ev;
    logic          final_gest;

    assign gest_ev = zc_pulse && (silence > GAP_L) && (silence <= LOSS_L);
    assign loss_ev = tick && !zc_pulse && (silence == LOSS_L);

    // silence length in ticks, saturating one past the loss limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            silence <= '0;
        end else if (zc_pulse) begin
            silence <= '0;
        end else if (tick && (silence <= LOSS_L)) begin
            silence <= silence + G_ONE;
        end
    end

    generate
        if (GESTURES > 1 && WINDOW_TICKS > 0) begin : g_multi
            localparam int CW = $clog2(GESTURES + 1);
            localparam int WW = $clog2(WINDOW_TICKS + 1);
            localparam logic [CW-1:0] LAST_L  = CW'(GESTURES - 1);
            localparam logic [CW-1:0] C_ONE   = CW'(1);
            localparam logic [WW-1:0] WIN_END = WW'(WINDOW_TICKS - 1);
            localparam logic [WW-1:0] W_ONE   = WW'(1);

            logic [CW-1:0] seen;
            logic [WW-1:0] win;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    seen <= '0;
                    win  <= '0;
                end else if (loss_ev) begin
                    seen <= '0;
                    win  <= '0;
                end else if (gest_ev) begin
                    win  <= '0;
                    seen <= (seen == LAST_L) ? '0 : seen + C_ONE;
                end else if ((seen != '0) && tick) begin
                    if (win == WIN_END) begin
                        seen <= '0;
                        win  <= '0;
                    end else begin
                        win <= win + W_ONE;
                    end
                end
            end

            assign final_gest = (seen == LAST_L);
        end else begin : g_single
            assign final_gest = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q  <= 1'b0;
            loss_q <= 1'b0;
        end else begin
            ovr_q  <= gest_ev && final_gest;
            loss_q <= loss_ev;
        end
    end

endmodule

// File: rtl/ovr_init_timer.sv
module ovr_init_timer #(
    parameter int INIT_TICKS       = 30000,
    parameter int TEST_ENTRY_TICKS = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic init_done,
    output logic test_win
);

    localparam int IW = $clog2(INIT_TICKS + 1);
    localparam logic [IW-1:0] INIT_L = IW'(INIT_TICKS);
    localparam logic [IW-1:0] TE_L   = IW'(TEST_ENTRY_TICKS);
    localparam logic [IW-1:0] I_ONE  = IW'(1);

    logic [IW-1:0] elapsed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (restart) begin
            elapsed <= '0;
        end else if (tick && (elapsed < INIT_L)) begin
            elapsed <= elapsed + I_ONE;
        end
    end

    assign init_done = (elapsed >= INIT_L);
    assign test_win  = (elapsed < TE_L);

endmodule

// File: rtl/ovr_mode_fsm.sv
module ovr_mode_fsm
    import ovr_pkg::*;
#(
    parameter int TEST_IDLE_TICKS = 5000,
    parameter int REVERT_TICKS    = 28800000,
    parameter int FLASH_EN        = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] mode_sel,
    input  logic       trig_valid,
    input  logic       ovr,
    input  logic       loss,
    input  logic       init_done,
    input  logic       test_win,
    output ovr_state_e state_q,
    output logic       flash_slow,
    output logic       flash_fast
);

    localparam int RW = $clog2(REVERT_TICKS + 1);
    localparam int DW = $clog2(TEST_IDLE_TICKS + 2);
    localparam logic [RW-1:0] REV_END = RW'(REVERT_TICKS - 1);
    localparam logic [RW-1:0] R_ONE   = RW'(1);
    localparam logic [DW-1:0] IDLE_L  = DW'(TEST_IDLE_TICKS);
    localparam logic [DW-1:0] D_ONE   = DW'(1);
    localparam logic          FL_ON   = (FLASH_EN != 0);

    ovr_state_e    nxt;
    logic [RW-1:0] on_time;
    logic [DW-1:0] idle;
    logic          rev_hit;
    logic          idle_hit;
    logic          slow_d;
    logic          fast_d;

    assign rev_hit  = (state_q == ST_OVR_ON) && tick && (on_time == REV_END);
    assign idle_hit = (state_q == ST_TEST) && tick && !trig_valid && (idle == IDLE_L);

    // time spent in override-on
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_time <= '0;
        end else if (state_q != ST_OVR_ON) begin
            on_time <= '0;
        end else if (tick) begin
            on_time <= on_time + R_ONE;
        end
    end

    // ticks without a trigger while in test
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle <= '0;
        end else if ((state_q != ST_TEST) || trig_valid) begin
            idle <= '0;
        end else if (tick && (idle <= IDLE_L)) begin
            idle <= idle + D_ONE;
        end
    end

    always_comb begin
        nxt    = state_q;
        slow_d = 1'b0;
        fast_d = 1'b0;
        if (mode_sel == SEL_ON) begin
            nxt = ST_FORCE_ON;
        end else if (mode_sel == SEL_OFF) begin
            nxt = ST_FORCE_OFF;
        end else if ((state_q == ST_FORCE_ON) || (state_q == ST_FORCE_OFF)) begin
            nxt = (init_done && !loss) ? ST_AUTO : ST_WARM;
        end else if (loss) begin
            nxt = ST_WARM;
        end else begin
            unique case (state_q)
                ST_WARM: begin
                    if (ovr && test_win) begin
                        nxt    = ST_TEST;
                        slow_d = 1'b1;
                    end else if (init_done) begin
                        nxt = ST_AUTO;
                    end
                end
                ST_TEST: begin
                    if (idle_hit) begin
                        nxt    = init_done ? ST_AUTO : ST_WARM;
                        fast_d = 1'b1;
                    end
                end
                ST_AUTO: begin
                    if (ovr) begin
                        nxt    = ST_OVR_ON;
                        slow_d = 1'b1;
                    end
                end
                ST_OVR_ON: begin
                    if (ovr || rev_hit) begin
                        nxt    = ST_AUTO;
                        fast_d = 1'b1;
                    end
                end
                default: nxt = ST_WARM;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WARM;
        end else begin
            state_q <= nxt;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flash_slow <= 1'b0;
            flash_fast <= 1'b0;
        end else begin
            flash_slow <= slow_d & FL_ON;
            flash_fast <= fast_d & FL_ON;
        end
    end

endmodule

// File: rtl/ovr_mode_ctrl.sv
module ovr_mode_ctrl
    import ovr_pkg::*;
#(
    parameter int GAP_TICKS        = 40,
    parameter int LOSS_TICKS       = 3000,
    parameter int WINDOW_TICKS     = 3000,
    parameter int GESTURES         = 1,
    parameter int TEST_ENTRY_TICKS = 10000,
    parameter int INIT_TICKS       = 30000,
    parameter int TEST_IDLE_TICKS  = 5000,
    parameter int HOUR_TICKS       = 3600000,
    parameter int REVERT_HOURS     = 8,
    parameter int FLASH_EN         = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       zc_pulse,
    input  logic [1:0] mode_sel,
    input  logic       trig_valid,
    output logic [2:0] state_o,
    output logic       trig_en,
    output logic       flash_slow,
    output logic       flash_fast
);

    localparam int REVERT_TICKS = REVERT_HOURS * HOUR_TICKS;

    logic       ovr;
    logic       loss;
    logic       init_done;
    logic       test_win;
    ovr_state_e st;

    ovr_zc_gesture #(
        .GAP_TICKS   (GAP_TICKS),
        .LOSS_TICKS  (LOSS_TICKS),
        .WINDOW_TICKS(WINDOW_TICKS),
        .GESTURES    (GESTURES)
    ) u_gest (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .zc_pulse(zc_pulse),
        .ovr_q   (ovr),
        .loss_q  (loss)
    );

    ovr_init_timer #(
        .INIT_TICKS      (INIT_TICKS),
        .TEST_ENTRY_TICKS(TEST_ENTRY_TICKS)
    ) u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (loss),
        .init_done(init_done),
        .test_win (test_win)
    );

    ovr_mode_fsm #(
        .TEST_IDLE_TICKS(TEST_IDLE_TICKS),
        .REVERT_TICKS   (REVERT_TICKS),
        .FLASH_EN       (FLASH_EN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode_sel  (mode_sel),
        .trig_valid(trig_valid),
        .ovr       (ovr),
        .loss      (loss),
        .init_done (init_done),
        .test_win  (test_win),
        .state_q   (st),
        .flash_slow(flash_slow),
        .flash_fast(flash_fast)
    );

    assign state_o = st;
    assign trig_en = (st == ST_TEST) || (st == ST_AUTO);

endmodule

// File: rtl/ovr_mode_ctrl_chk.sv
module ovr_mode_ctrl_chk
    import ovr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic [2:0] state_o,
    input logic       flash_slow,
    input logic       flash_fast
);

    assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd5);

    assert_force_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == SEL_ON) |=> (state_o == 3'd4));

    assert_force_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == SEL_OFF) |=> (state_o == 3'd5));

    assert_no_flash_forced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_sel == SEL_ON) || (mode_sel == SEL_OFF)) |=> (!flash_slow && !flash_fast));

    assert_slow_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flash_slow |-> ((state_o == 3'd1) || (state_o == 3'd3)));

    assert_fast_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flash_fast |-> ((state_o == 3'd0) || (state_o == 3'd2)));

    assert_ovr_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd3) && ($past(state_o) != 3'd3)) |-> ($past(state_o) == 3'd2));

    assert_test_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd1) && ($past(state_o) != 3'd1)) |-> ($past(state_o) == 3'd0));

endmodule

bind ovr_mode_ctrl ovr_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .state_o   (state_o),
    .flash_slow(flash_slow),
    .flash_fast(flash_fast)
);

// File: tb/sim_ovr_mode_ctrl.sv
module sim_ovr_mode_ctrl;

    localparam int GAP   = 3;
    localparam int LOSS  = 12;
    localparam int WIN   = 20;
    localparam int GEST  = 2;
    localparam int TE    = 40;
    localparam int INIT  = 200;
    localparam int IDLE  = 25;
    localparam int HOUR  = 10;
    localparam int HRS   = 4;
    localparam int REV   = HOUR * HRS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       zc_pulse = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       trig_valid = 1'b0;
    logic [2:0] state_o;
    logic       trig_en;
    logic       flash_slow;
    logic       flash_fast;

    int    nchk = 0;
    int    nfail = 0;
    string cur_req = "R1";
    bit    line_on = 1'b1;
    bit    zph = 1'b0;
    bit    saw_slow = 1'b0;
    bit    saw_fast = 1'b0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    ovr_mode_ctrl #(
        .GAP_TICKS(GAP), .LOSS_TICKS(LOSS), .WINDOW_TICKS(WIN), .GESTURES(GEST),
        .TEST_ENTRY_TICKS(TE), .INIT_TICKS(INIT), .TEST_IDLE_TICKS(IDLE),
        .HOUR_TICKS(HOUR), .REVERT_HOURS(HRS), .FLASH_EN(1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .zc_pulse(zc_pulse),
        .mode_sel(mode_sel), .trig_valid(trig_valid), .state_o(state_o),
        .trig_en(trig_en), .flash_slow(flash_slow), .flash_fast(flash_fast)
    );

    // stimulus generators: tick every other cycle, zero-cross every other cycle
    always @(negedge clk) begin
        tick     <= ~tick;
        zc_pulse <= line_on && zph;
        zph      <= ~zph;
    end

    // behavioural reference model
    int m_gap, m_cnt, m_win, m_since, m_rev, m_idle, m_st, n_st;
    bit m_ovr, m_loss, m_fs, m_ff, gev, lev, rev_hit, idle_hit, n_fs, n_ff;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_gap = 0; m_cnt = 0; m_win = 0; m_since = 0; m_rev = 0; m_idle = 0;
            m_st = 0; m_ovr = 0; m_loss = 0; m_fs = 0; m_ff = 0;
        end else begin
            gev      = zc_pulse && (m_gap > GAP) && (m_gap <= LOSS);
            lev      = tick && !zc_pulse && (m_gap == LOSS);
            rev_hit  = (m_st == 3) && tick && (m_rev == REV - 1);
            idle_hit = (m_st == 1) && tick && !trig_valid && (m_idle == IDLE);
            n_st = m_st; n_fs = 0; n_ff = 0;
            if (mode_sel == 2'b01) n_st = 4;
            else if (mode_sel == 2'b10) n_st = 5;
            else if (m_st >= 4) n_st = (m_since >= INIT && !m_loss) ? 2 : 0;
            else if (m_loss) n_st = 0;
            else if (m_st == 0) begin
                if (m_ovr && m_since < TE) begin n_st = 1; n_fs = 1; end
                else if (m_since >= INIT) n_st = 2;
            end else if (m_st == 1) begin
                if (idle_hit) begin n_st = (m_since >= INIT) ? 2 : 0; n_ff = 1; end
            end else if (m_st == 2) begin
                if (m_ovr) begin n_st = 3; n_fs = 1; end
            end else begin
                if (m_ovr || rev_hit) begin n_st = 2; n_ff = 1; end
            end
            if (m_st != 3) m_rev = 0; else if (tick) m_rev++;
            if (m_st != 1 || trig_valid) m_idle = 0;
            else if (tick && m_idle <= IDLE) m_idle++;
            if (m_loss) m_since = 0; else if (tick && m_since < INIT) m_since++;
            m_ovr = gev && (m_cnt == GEST - 1);
            if (lev) begin m_cnt = 0; m_win = 0; end
            else if (gev) begin m_win = 0; m_cnt = (m_cnt == GEST - 1) ? 0 : m_cnt + 1; end
            else if (m_cnt != 0 && tick) begin
                if (m_win == WIN - 1) begin m_cnt = 0; m_win = 0; end else m_win++;
            end
            if (zc_pulse) m_gap = 0; else if (tick && m_gap <= LOSS) m_gap++;
            m_loss = lev;
            m_st = n_st; m_fs = n_fs; m_ff = n_ff;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            nchk++;
            if (int'(state_o) != m_st || trig_en != (m_st == 1 || m_st == 2) ||
                flash_slow != m_fs || flash_fast != m_ff) begin
                nfail++;
                $display("FAIL %s: state/en/slow/fast actual %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
                         cur_req, state_o, trig_en, flash_slow, flash_fast,
                         m_st, (m_st == 1 || m_st == 2), m_fs, m_ff);
            end
            if (flash_slow) saw_slow = 1'b1;
            if (flash_fast) saw_fast = 1'b1;
        end
    end

    task automatic chk(input string req, input int actual, input int expected);
        nchk++;
        if (actual != expected) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic flick();
        line_on = 1'b0;
        wait_cyc(14);
        line_on = 1'b1;
        wait_cyc(10);
    endtask

    task automatic clear_flags();
        saw_slow = 1'b0;
        saw_fast = 1'b0;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        cur_req = "R1";
        chk("R1 reset state", state_o, 0);
        chk("R1 reset trig_en", trig_en, 0);
        chk("R1 reset flash", flash_slow | flash_fast, 0);

        cur_req = "R3";
        clear_flags();
        flick();
        flick();
        wait_cyc(4);
        chk("R3 early override enters TEST", state_o, 1);
        chk("R2 two gestures in window", trig_en, 1);
        chk("R10 slow flash on test entry", saw_slow, 1);

        cur_req = "R4";
        clear_flags();
        for (int i = 0; i < 5; i++) begin
            trig_valid = 1'b1;
            wait_cyc(1);
            trig_valid = 1'b0;
            wait_cyc(19);
        end
        chk("R4 triggers hold TEST", state_o, 1);
        wait_cyc(60);
        chk("R4 idle exit before init goes to WARM", state_o, 0);
        chk("R10 fast flash on test exit", saw_fast, 1);

        cur_req = "R5";
        wait_cyc(250);
        chk("R5 warm-up done gives AUTO", state_o, 2);
        chk("R5 trig_en in AUTO", trig_en, 1);

        cur_req = "R11";
        clear_flags();
        flick();
        wait_cyc(60);
        flick();
        wait_cyc(60);
        chk("R11 lone gestures expire", state_o, 2);
        chk("R11 no flash on expired gesture", saw_slow | saw_fast, 0);

        cur_req = "R6";
        flick();
        flick();
        wait_cyc(4);
        chk("R6 override sets OVR_ON", state_o, 3);
        chk("R6 trig_en off in OVR_ON", trig_en, 0);

        cur_req = "R7";
        clear_flags();
        wait_cyc(40);
        chk("R7 still OVR_ON before timeout", state_o, 3);
        wait_cyc(60);
        chk("R7 revert to AUTO", state_o, 2);
        chk("R10 fast flash on revert", saw_fast, 1);

        cur_req = "R6";
        flick();
        flick();
        wait_cyc(4);
        chk("R6 override sets OVR_ON again", state_o, 3);
        flick();
        flick();
        wait_cyc(4);
        chk("R6 override clears OVR_ON", state_o, 2);

        cur_req = "R9";
        clear_flags();
        mode_sel = 2'b01;
        wait_cyc(3);
        chk("R9 forced on", state_o, 4);
        flick();
        flick();
        wait_cyc(4);
        chk("R9 gestures ignored while forced", state_o, 4);
        mode_sel = 2'b10;
        wait_cyc(3);
        chk("R9 forced off", state_o, 5);
        mode_sel = 2'b11;
        wait_cyc(3);
        chk("R9 release to AUTO", state_o, 2);
        chk("R10 no flash on selector changes", saw_slow | saw_fast, 0);

        cur_req = "R8";
        line_on = 1'b0;
        wait_cyc(40);
        line_on = 1'b1;
        wait_cyc(4);
        chk("R8 loss restarts warm-up", state_o, 0);
        chk("R8 trig_en off after loss", trig_en, 0);
        wait_cyc(200);
        chk("R8 initial time restarted from zero", state_o, 0);
        wait_cyc(250);
        chk("R8 full initial time then AUTO", state_o, 2);

        summary();
    end

endmodule